// File: doc/BRIEF.md
# Programmable Priority Interrupt Controller

This block collects up to eight interrupt requests, decides which one the processor should take next, and raises a single interrupt line. A rising edge on a request input is held in a pending-request register. A software-written mask removes individual inputs from arbitration without losing the pending request. Requests are compared against the levels that are already in service. When the processor acknowledges, the controller puts an 8-bit vector number on its read-data bus, moves the winner from pending to in-service, and lowers the interrupt line until a request that outranks every in-service level appears.

Software reaches the block through an 8-bit bus with a single address bit, qualified by a select and separate read and write strobes. One location holds the mask. The other takes commands: end-of-interrupt commands, either nonspecific (clear the most urgent in-service level) or naming a level, and a load of the vector base. An end-of-interrupt can also rotate priority so that the level just finished becomes the least urgent, which shares service fairly among equal-importance sources. All inputs are assumed synchronous to `clk`.

Top module: `prio_irq_ctrl`

## Requirements
- R1: During and after synchronous active-low reset, the pending register, in-service register and mask read 0, the interrupt line is low, the vector base is 0 and priority is fixed with input 0 most urgent and input 7 least urgent.
- R2: A 0-to-1 transition on request input i sets bit i of the pending register one clock later; a bus read with address 0 returns the pending register; acknowledging input i clears its pending bit.
- R3: A write with address 1 loads the mask and a read with address 1 returns it; a set mask bit keeps that input out of arbitration while its pending bit stays set, and clearing the mask bit lets it compete again.
- R4: Without rotation, a lower input number always beats a higher one when both are pending.
- R5: `irq_out` is high exactly when some unmasked pending input is more urgent than every in-service level; a pending input of equal or lower urgency than an in-service level is held back, and a more urgent one raises `irq_out` while the other is still in service.
- R6: In a cycle where `irq_ack` is high and `irq_out` is high, `bus_rdata` shows the vector {base[4:0], winner[2:0]} and at the clock edge the winner's in-service bit is set and `irq_out` falls; an `irq_ack` while `irq_out` is low changes nothing and `bus_rdata` reads 0.
- R7: A command write (address 0) with bit 7 = 0 and bit 5 = 0 is a nonspecific end-of-interrupt that clears the most urgent in-service bit; with nothing in service it has no effect.
- R8: A command write with bit 7 = 0 and bit 5 = 1 is a specific end-of-interrupt that clears the in-service bit of the level in bits 2:0.
- R9: Bit 6 of an end-of-interrupt command requests rotation: the level that was cleared (or named, for a specific command) becomes least urgent and the next higher number becomes most urgent; without bit 6 the priority order is unchanged.
- R10: A command write with bit 7 = 1 loads bits 4:0 into the vector base, which forms bits 7:3 of every later vector.
- R11: Writes and reads take effect only while `bus_sel` is high; a write with `bus_sel` low leaves all state unchanged and a read with `bus_sel` low returns 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_sel | input | 1 | Select, qualifies both strobes |
| bus_addr | input | 1 | 0 = command / pending register, 1 = mask |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, or vector during acknowledge |
| irq_req | input | 8 | Request inputs, rising-edge sensitive |
| irq_ack | input | 1 | Acknowledge from the processor |
| irq_out | output | 1 | Interrupt request to the processor |

## Verification
The hardest situation to reach is a nonspecific end-of-interrupt with two levels in service at once, because the bus never exposes the in-service register. The stimulus builds it by acknowledging a low-urgency input, then raising a more urgent one so it preempts and is acknowledged too; after the end-of-interrupt it raises a third input ranked between the two, and only the correct choice of cleared level lets that input raise the interrupt line. Rotation is reached the same way, by following each rotating command with simultaneous requests whose winner differs under fixed and rotated order.

// File: rtl/prio_pkg.sv
// Shared constants and the decoded command record for the interrupt controller.
// Assumes eight inputs and an 8-bit bus; the command bit positions sit at the
// top of the data word.
package prio_pkg;
    localparam int PIC_N      = 8;
    localparam int PIC_IDX_W  = 3;
    localparam int PIC_DATA_W = 8;

    // Decoded view of a write to the command location.
    typedef struct packed {
        logic                 base_load;
        logic                 eoi;
        logic                 rotate;
        logic                 specific;
        logic [PIC_IDX_W-1:0] level;
    } prio_cmd_t;
endpackage

// File: rtl/prio_pick.sv
// Rotating priority picker: finds the most urgent set bit of vec, where the
// bit just above `lowest` is most urgent and `lowest` itself is least urgent.
// Also reports the rank (0 = most urgent). Assumes N is a power of two.
module prio_pick #(
    parameter int N     = 8,
    parameter int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     vec,
    input  logic [IDX_W-1:0] lowest,
    output logic             found,
    output logic [IDX_W-1:0] idx,
    output logic [IDX_W-1:0] rank
);
    logic [IDX_W-1:0] cand;

    // Scan from least to most urgent so the last hit is the most urgent one.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        rank  = '0;
        cand  = '0;
        for (int r = N - 1; r >= 0; r--) begin
            cand = lowest + IDX_W'(r + 1);
            if (vec[cand]) begin
                found = 1'b1;
                idx   = cand;
                rank  = IDX_W'(r);
            end
        end
    end

    // The reported winner must be a set bit of the input vector (R4).
    always_comb begin
        if (found) begin
            assert_pick_valid_R4: assert (vec[idx]);
        end
    end
endmodule

// File: rtl/prio_req_latch.sv
// Pending-request register: captures rising edges of the request inputs and
// holds them until the acknowledge logic clears the winner. Inputs are
// assumed already synchronous to clk. A new edge wins over a same-cycle clear.
module prio_req_latch #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req_in,
    input  logic [N-1:0] clr,
    output logic [N-1:0] pend
);
    logic [N-1:0] req_q;
    logic [N-1:0] rise;

    assign rise = req_in & ~req_q;

    // Remember last input level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) req_q <= '0;
        else        req_q <= req_in;
    end

    // Set on edge, clear on acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) pend <= '0;
        else        pend <= (pend & ~clr) | rise;
    end

    assert_edge_latched_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rise != '0) |=> ((pend & $past(rise)) == $past(rise)));
endmodule

// File: rtl/prio_irq_ctrl.sv
// Eight-input priority interrupt controller, top level. Holds the mask,
// in-service register, rotation pointer and vector base, decodes bus writes,
// arbitrates pending against in-service levels and answers the acknowledge
// with a vector. Assumes a single-cycle irq_ack and synchronous inputs.
module prio_irq_ctrl
    import prio_pkg::*;
#(
    parameter int N      = PIC_N,
    parameter int DATA_W = PIC_DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [N-1:0]      irq_req,
    input  logic              irq_ack,
    output logic              irq_out
);
    localparam int IDX_W    = $clog2(N);
    localparam int BASE_W   = DATA_W - IDX_W;
    localparam int B_BASE   = DATA_W - 1;
    localparam int B_ROT    = DATA_W - 2;
    localparam int B_SPEC   = DATA_W - 3;

    logic [N-1:0]      pend;
    logic [N-1:0]      imr;
    logic [N-1:0]      isr;
    logic [IDX_W-1:0]  lowest;
    logic [BASE_W-1:0] vbase;

    logic              p_found, s_found;
    logic [IDX_W-1:0]  p_idx, s_idx, p_rank, s_rank;
    logic              take;
    logic [N-1:0]      take_mask;
    logic [N-1:0]      eoi_clr;
    logic              eoi_hit;
    logic [IDX_W-1:0]  eoi_lvl;
    logic              wr_cmd, wr_mask, rd_hit;
    prio_cmd_t         cmd;

    // Bus strobe qualification.
    assign wr_cmd  = bus_sel & bus_wr & ~bus_addr;
    assign wr_mask = bus_sel & bus_wr &  bus_addr;
    assign rd_hit  = bus_sel & bus_rd;

    // Split a command write into its fields.
    always_comb begin
        cmd.base_load = wr_cmd &  bus_wdata[B_BASE];
        cmd.eoi       = wr_cmd & ~bus_wdata[B_BASE];
        cmd.rotate    = bus_wdata[B_ROT];
        cmd.specific  = bus_wdata[B_SPEC];
        cmd.level     = bus_wdata[IDX_W-1:0];
    end

    prio_req_latch #(.N(N)) u_req (
        .clk    (clk),
        .rst_n  (rst_n),
        .req_in (irq_req),
        .clr    (take_mask),
        .pend   (pend)
    );

    prio_pick #(.N(N), .IDX_W(IDX_W)) u_pick_pend (
        .vec    (pend & ~imr),
        .lowest (lowest),
        .found  (p_found),
        .idx    (p_idx),
        .rank   (p_rank)
    );

    prio_pick #(.N(N), .IDX_W(IDX_W)) u_pick_svc (
        .vec    (isr),
        .lowest (lowest),
        .found  (s_found),
        .idx    (s_idx),
        .rank   (s_rank)
    );

    // Raise the line only when the best request outranks all in-service levels.
    assign irq_out   = p_found & (~s_found | (p_rank < s_rank));
    assign take      = irq_ack & irq_out;
    assign take_mask = take ? (N'(1) << p_idx) : '0;

    // Work out which in-service level an end-of-interrupt releases.
    always_comb begin
        eoi_hit = 1'b0;
        eoi_lvl = '0;
        if (cmd.eoi) begin
            if (cmd.specific) begin
                eoi_hit = 1'b1;
                eoi_lvl = cmd.level;
            end else if (s_found) begin
                eoi_hit = 1'b1;
                eoi_lvl = s_idx;
            end
        end
        eoi_clr = eoi_hit ? (N'(1) << eoi_lvl) : '0;
    end

    // In-service register: release on end-of-interrupt, claim on acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) isr <= '0;
        else        isr <= (isr & ~eoi_clr) | take_mask;
    end

    // Rotation pointer marks the least urgent level.
    always_ff @(posedge clk) begin
        if (!rst_n)                       lowest <= IDX_W'(N - 1);
        else if (eoi_hit && cmd.rotate)   lowest <= eoi_lvl;
    end

    // Mask register load.
    always_ff @(posedge clk) begin
        if (!rst_n)       imr <= '0;
        else if (wr_mask) imr <= bus_wdata[N-1:0];
    end

    // Vector base load.
    always_ff @(posedge clk) begin
        if (!rst_n)             vbase <= '0;
        else if (cmd.base_load) vbase <= bus_wdata[BASE_W-1:0];
    end

    // Read path: vector during a taken acknowledge, else register reads.
    always_comb begin
        bus_rdata = '0;
        if (take)        bus_rdata = {vbase, p_idx};
        else if (rd_hit) bus_rdata = bus_addr ? DATA_W'(imr) : DATA_W'(pend);
    end

    assert_irq_has_source_R5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> ((pend & ~imr) != '0));

    assert_ack_claims_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !cmd.eoi) |=> ($countones(isr) == $countones($past(isr)) + 1));

    assert_eoi_releases_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd.eoi && !take) |=> ($countones(isr) <= $countones($past(isr))));

    assert_mask_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_mask |=> $stable(imr));

    assert_idle_ack_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack && !irq_out && !cmd.eoi) |=> $stable(isr));
endmodule

// File: tb/prio_irq_ctrl_bench.sv
// Scoreboard bench: driver tasks queue expected observations, a monitor on the
// falling edge pops and compares them against the ports.
module prio_irq_ctrl_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_sel = 1'b0, bus_addr = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [7:0] irq_req = '0;
    logic       irq_ack = 1'b0;
    logic       irq_out;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    logic obs_req = 1'b0;

    typedef struct {
        bit         is_irq;
        logic [7:0] exp;
        string      tag;
    } item_t;
    item_t sb[$];

    always #10 clk = ~clk;

    prio_irq_ctrl u_prio_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq_req(irq_req), .irq_ack(irq_ack),
        .irq_out(irq_out)
    );

    // Monitor: compare the oldest expectation with the ports.
    always @(negedge clk) begin
        if (obs_req && sb.size() > 0) begin
            item_t it;
            logic [7:0] act;
            it  = sb.pop_front();
            act = it.is_irq ? {7'b0, irq_out} : bus_rdata;
            checks++;
            if (act !== it.exp) begin
                fails++;
                $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
            end
        end
    end

    task automatic look(input bit is_irq, input logic [7:0] exp, input string tag);
        item_t it;
        it.is_irq = is_irq; it.exp = exp; it.tag = tag;
        sb.push_back(it);
        obs_req = 1'b1;
        @(negedge clk);
        #1 obs_req = 1'b0;
    endtask

    task automatic wr(input bit a, input logic [7:0] d, input bit sel = 1'b1);
        @(posedge clk); #1;
        bus_sel = sel; bus_addr = a; bus_wr = 1'b1; bus_wdata = d;
        @(posedge clk); #1;
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd_chk(input bit a, input logic [7:0] exp, input string tag,
                          input bit sel = 1'b1);
        @(posedge clk); #1;
        bus_sel = sel; bus_addr = a; bus_rd = 1'b1;
        look(1'b0, exp, tag);
        @(posedge clk); #1;
        bus_sel = 1'b0; bus_rd = 1'b0;
    endtask

    task automatic ack_chk(input logic [7:0] exp, input string tag);
        @(posedge clk); #1;
        irq_ack = 1'b1;
        look(1'b0, exp, tag);
        @(posedge clk); #1;
        irq_ack = 1'b0;
    endtask

    task automatic irq_chk(input bit exp, input string tag);
        @(posedge clk); #1;
        look(1'b1, {7'b0, exp}, tag);
    endtask

    task automatic raise(input logic [7:0] m);
        @(posedge clk); #1 irq_req = irq_req | m;
    endtask

    task automatic drop_all();
        @(posedge clk); #1 irq_req = '0;
        @(posedge clk);
    endtask

    // Watchdog: a hung run counts as one failure and still reports.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected=<100000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        // R1: state while and after leaving reset
        irq_chk(1'b0, "R1 irq low in reset");
        @(posedge clk); #1 rst_n = 1'b1;
        rd_chk(1'b0, 8'h00, "R1 pending clear");
        rd_chk(1'b1, 8'h00, "R1 mask clear");
        irq_chk(1'b0, "R1 irq low");

        // R2 R4 R5 R6: simultaneous IR4 and IR6, fixed order
        raise(8'h50);
        irq_chk(1'b1, "R5 irq raised");
        rd_chk(1'b0, 8'h50, "R2 both latched");
        ack_chk(8'h04, "R4 R6 IR4 wins, vector");
        irq_chk(1'b0, "R5 lower IR6 held back");
        rd_chk(1'b0, 8'h40, "R2 acked bit cleared");

        // R9: rotating nonspecific EOI demotes IR4, IR6 next
        wr(1'b0, 8'h40);
        irq_chk(1'b1, "R9 IR6 forwarded after EOI");
        ack_chk(8'h06, "R9 IR6 vector");
        wr(1'b0, 8'h40);            // lowest becomes 6
        drop_all();
        raise(8'h81);
        ack_chk(8'h07, "R9 IR7 beats IR0 after rotation");
        irq_chk(1'b0, "R5 R9 IR0 ranked below IR7");

        // R8: specific EOI for level 7 without rotation
        wr(1'b0, 8'h27);
        irq_chk(1'b1, "R8 level 7 released");
        ack_chk(8'h00, "R8 IR0 vector");
        wr(1'b0, 8'h60);            // specific rotate level 0: lowest = 0
        drop_all();
        raise(8'h03);
        ack_chk(8'h01, "R9 specific rotate makes IR1 most urgent");
        wr(1'b0, 8'h00);
        ack_chk(8'h00, "R7 IR0 after nonspecific EOI");
        wr(1'b0, 8'h00);

        // R10 R3: vector base and masking
        wr(1'b0, 8'h8A);
        wr(1'b1, 8'h02);
        rd_chk(1'b1, 8'h02, "R3 mask readback");
        drop_all();
        raise(8'h22);
        ack_chk(8'h55, "R3 R10 masked IR1 skipped, base applied");
        wr(1'b0, 8'h00);
        irq_chk(1'b0, "R3 masked request not forwarded");
        rd_chk(1'b0, 8'h02, "R3 masked request still pending");
        wr(1'b1, 8'h00);
        irq_chk(1'b1, "R3 unmasked request forwarded");
        ack_chk(8'h51, "R3 R10 IR1 vector");

        // R5: equal level held back while in service
        drop_all();
        raise(8'h02);
        irq_chk(1'b0, "R5 equal level blocked");
        wr(1'b0, 8'h00);
        irq_chk(1'b1, "R5 equal level after EOI");
        ack_chk(8'h51, "R6 IR1 again");
        wr(1'b0, 8'h00);

        // R5 R7: preemption, then nonspecific EOI picks the most urgent
        raise(8'h40);
        ack_chk(8'h56, "R6 IR6 vector");
        raise(8'h08);
        irq_chk(1'b1, "R5 IR3 preempts IR6");
        ack_chk(8'h53, "R6 IR3 vector");
        wr(1'b0, 8'h00);            // must release IR3, keep IR6
        raise(8'h10);
        irq_chk(1'b1, "R7 IR4 outranks remaining IR6");
        ack_chk(8'h54, "R7 IR4 vector");
        wr(1'b0, 8'h00);
        wr(1'b0, 8'h00);
        raise(8'h80);
        irq_chk(1'b1, "R7 all released, IR7 forwarded");
        ack_chk(8'h57, "R6 IR7 vector");
        wr(1'b0, 8'h00);

        // R11: select qualifies bus access
        wr(1'b1, 8'hFF, 1'b0);
        rd_chk(1'b1, 8'h00, "R11 unselected write ignored");
        rd_chk(1'b1, 8'h00, "R11 unselected read is zero", 1'b0);

        // R6: acknowledge with nothing to give
        drop_all();
        ack_chk(8'h00, "R6 idle ack reads zero");
        raise(8'h20);
        irq_chk(1'b1, "R6 idle ack left state alone");
        ack_chk(8'h55, "R6 IR5 vector");
        irq_chk(1'b0, "R6 irq falls after ack");

        repeat (2) @(posedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule